// File: doc/BRIEF.md
# UART Baud Tick Generator

This block turns a single 32-bit configuration word into a periodic one-cycle baud tick for a serial transmitter and receiver. The whole block runs on one system clock. Two reference sources arrive as single-cycle enable strobes. The first is a system-clock strobe that always passes through a fixed divide-by-four. The second is a crystal strobe that passes through a two-bit selectable prescaler. A source-select bit picks one of the two prescaled references. A 23-bit programmable counter then divides the chosen reference by N+1.

Software computes N as the prescaled reference rate divided by the baud rate, rounded to the nearest integer, minus one. The speed may only change while the transmitter is empty, so the block takes a `tx_idle` input. A write that arrives while the transmitter is busy is parked and takes effect as soon as `tx_idle` goes high. Any change to the timing fields restarts every counter, so no shortened tick is produced. A build parameter selects a legacy variant in which the prescaler field is fixed and the crystal path always divides by three.

Top module: `baud_tick_gen`

## Requirements
- R1: With the divider enabled, `baud_tick` pulses for one cycle once every N+1 pulses of the selected prescaled reference, where N is `cfg_wdata[22:0]`.
- R2: While bit 23 of the active configuration is 0, no baud tick is produced and all counters stay at zero.
- R3: Bit 24 selects the reference. 0 uses the system strobe path and 1 uses the crystal strobe path.
- R4: On the crystal path, bits [27:26] set the prescaler: 00 divides by 3, 01 by 1, 10 by 2 and 11 by 2.
- R5: With parameter LEGACY_MODE=1, bits [27:26] ignore writes and read back as 0, so the crystal path always divides by 3.
- R6: The system strobe path divides by a fixed SYS_PRESCALE (default 4) before the programmable divider.
- R7: Bits [31:28] and bit 25 read back as 0 whatever value was written.
- R8: A write with `tx_idle` high takes effect at that clock edge. A write with `tx_idle` low is held pending, and the old settings keep running. `cfg_rdata` shows the pending value, which is applied on the first cycle that `tx_idle` is high.
- R9: When N, bit 24 or bits [27:26] change, all prescaler and divider counters restart from zero. The first new tick then comes exactly one full new period after the edge where the change took effect.
- R10: Synchronous active-high `rst` clears the configuration (readback 0) and all counters. No tick occurs until bit 23 is written to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| tx_idle | input | 1 | High when the transmitter is empty; gates when settings are applied |
| sys_stb | input | 1 | System reference enable strobe |
| xtal_stb | input | 1 | Crystal reference enable strobe |
| cfg_rdata | output | 32 | Configuration readback (pending value if one is waiting) |
| baud_tick | output | 1 | One-cycle baud tick |

## Verification
The tick period is measured with every prescaler code and with both reference sources. This separates the divide-by-three code from the two divide-by-two codes and from the pass-through code, and it separates the fixed system prescaler from the crystal one. A crystal strobe that fires only every other cycle shows that the divider counts reference pulses rather than clock cycles. The first interval after each reconfiguration is timed from the edge where the change took effect, which exposes a counter left mid-count. A write made while the transmitter is busy shows that the old period continues until `tx_idle` rises and the parked value then takes over.

// File: rtl/baud_pkg.sv
package baud_pkg;

    localparam int DIVCNT_W = 23;
    localparam int CFG_W    = 32;

    typedef enum logic [1:0] {
        XPRE_THIRD = 2'b00,
        XPRE_PASS  = 2'b01,
        XPRE_HALF  = 2'b10,
        XPRE_HALF2 = 2'b11
    } xtal_pre_e;

    // Field positions are the software-visible layout of the word
    typedef struct packed {
        logic [3:0]          rsv_top;
        xtal_pre_e           xpre;
        logic                rsv_mid;
        logic                use_xtal;
        logic                run;
        logic [DIVCNT_W-1:0] divn;
    } baud_cfg_t;

    function automatic logic [1:0] xpre_ratio(input xtal_pre_e code);
        case (code)
            XPRE_THIRD: return 2'd3;
            XPRE_PASS:  return 2'd1;
            default:    return 2'd2;
        endcase
    endfunction

    function automatic baud_cfg_t clean_cfg(input logic [CFG_W-1:0] raw, input bit legacy);
        baud_cfg_t c;
        c = baud_cfg_t'(raw);
        c.rsv_top = '0;
        c.rsv_mid = 1'b0;
        if (legacy) c.xpre = XPRE_THIRD;
        return c;
    endfunction

    function automatic logic timing_moved(input baud_cfg_t a, input baud_cfg_t b);
        return (a.divn != b.divn) || (a.use_xtal != b.use_xtal) || (a.xpre != b.xpre);
    endfunction

endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg
    import baud_pkg::*;
#(
    parameter bit LEGACY_MODE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             tx_idle,
    output baud_cfg_t        live_cfg,
    output logic             restart,
    output logic [CFG_W-1:0] cfg_rdata
);

    baud_cfg_t live_q, park_q, live_d, park_d, wr_cfg;
    logic      park_vld_q, park_vld_d;

    assign wr_cfg = clean_cfg(cfg_wdata, LEGACY_MODE);

    always_comb begin
        live_d     = live_q;
        park_d     = park_q;
        park_vld_d = park_vld_q;
        if (cfg_we) begin
            if (tx_idle) begin
                live_d     = wr_cfg;
                park_vld_d = 1'b0;
            end else begin
                park_d     = wr_cfg;
                park_vld_d = 1'b1;
            end
        end else if (park_vld_q && tx_idle) begin
            live_d     = park_q;
            park_vld_d = 1'b0;
        end
    end

    assign restart = timing_moved(live_d, live_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q     <= '0;
            park_q     <= '0;
            park_vld_q <= 1'b0;
        end else begin
            live_q     <= live_d;
            park_q     <= park_d;
            park_vld_q <= park_vld_d;
        end
    end

    assign live_cfg  = live_q;
    assign cfg_rdata = park_vld_q ? park_q : live_q;

    // R8
    busy_holds_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_idle |=> $stable(live_q));

    // R8
    park_apply_chk: assert property (@(posedge clk) disable iff (rst)
        (park_vld_q && tx_idle && !cfg_we) |=> (live_q == $past(park_q)));

    generate
        if (LEGACY_MODE) begin : g_legacy_chk
            // R5
            legacy_pre_chk: assert property (@(posedge clk) disable iff (rst)
                cfg_rdata[27:26] == 2'b00);
        end
    endgenerate

endmodule

// File: rtl/baud_ref_sel.sv
module baud_ref_sel
    import baud_pkg::*;
#(
    parameter int SYS_PRESCALE = 4
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      restart,
    input  logic      run,
    input  logic      use_xtal,
    input  xtal_pre_e xpre,
    input  logic      sys_stb,
    input  logic      xtal_stb,
    output logic      ref_pulse
);

    localparam int SYS_W = (SYS_PRESCALE > 1) ? $clog2(SYS_PRESCALE) : 1;

    logic       sys_hit, xtal_hit, clr;
    logic [1:0] xcnt_q, xlast;

    assign clr = rst || restart || !run;

    generate
        if (SYS_PRESCALE > 1) begin : g_sys_div
            logic [SYS_W-1:0] scnt_q;
            assign sys_hit = sys_stb && (scnt_q == SYS_W'(SYS_PRESCALE - 1));
            always_ff @(posedge clk) begin
                if (clr)          scnt_q <= '0;
                else if (sys_hit) scnt_q <= '0;
                else if (sys_stb) scnt_q <= scnt_q + 1'b1;
            end
        end else begin : g_sys_pass
            assign sys_hit = sys_stb;
        end
    endgenerate

    assign xlast    = xpre_ratio(xpre) - 2'd1;
    assign xtal_hit = xtal_stb && (xcnt_q == xlast);

    always_ff @(posedge clk) begin
        if (clr)           xcnt_q <= '0;
        else if (xtal_hit) xcnt_q <= '0;
        else if (xtal_stb) xcnt_q <= xcnt_q + 2'd1;
    end

    assign ref_pulse = run && (use_xtal ? xtal_hit : sys_hit);

    // R3
    ref_source_chk: assert property (@(posedge clk) disable iff (rst)
        ref_pulse |-> (use_xtal ? xtal_stb : sys_stb));

endmodule

// File: rtl/baud_divider.sv
module baud_divider
    import baud_pkg::*;
#(
    parameter int CNT_W = DIVCNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             run,
    input  logic [CNT_W-1:0] divn,
    input  logic             ref_pulse,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= 1'b0;
            if (ref_pulse) begin
                if (cnt_q == divn) begin
                    cnt_q <= '0;
                    tick  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R1
    tick_on_terminal_chk: assert property (@(posedge clk) disable iff (rst)
        tick |-> ($past(ref_pulse) && ($past(cnt_q) == $past(divn))));

    // R2
    stopped_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> !tick);

    // R9
    restart_clear_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> ((cnt_q == '0) && !tick));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter bit LEGACY_MODE  = 1'b0,
    parameter int SYS_PRESCALE = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    input  logic        tx_idle,
    input  logic        sys_stb,
    input  logic        xtal_stb,
    output logic [31:0] cfg_rdata,
    output logic        baud_tick
);

    baud_cfg_t live_cfg;
    logic      restart, ref_pulse;

    baud_cfg_reg #(.LEGACY_MODE(LEGACY_MODE)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .tx_idle   (tx_idle),
        .live_cfg  (live_cfg),
        .restart   (restart),
        .cfg_rdata (cfg_rdata)
    );

    baud_ref_sel #(.SYS_PRESCALE(SYS_PRESCALE)) u_ref (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .run       (live_cfg.run),
        .use_xtal  (live_cfg.use_xtal),
        .xpre      (live_cfg.xpre),
        .sys_stb   (sys_stb),
        .xtal_stb  (xtal_stb),
        .ref_pulse (ref_pulse)
    );

    baud_divider #(.CNT_W(DIVCNT_W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .run       (live_cfg.run),
        .divn      (live_cfg.divn),
        .ref_pulse (ref_pulse),
        .tick      (baud_tick)
    );

    // R7
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata[31:28] == 4'h0) && !cfg_rdata[25]);

    // R10
    reset_state_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ((cfg_rdata == 32'h0) && !baud_tick));

endmodule

// File: tb/baud_tick_gen_test.sv
`timescale 1ns/1ps
module baud_tick_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        tx_idle = 1'b1;
    logic        sys_stb = 1'b0;
    logic        xtal_stb = 1'b0;
    logic [31:0] rd, rd_l;
    logic        tick, tick_l;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    int last_ts = 0;
    int xgap = 1;
    bit mon_leg = 1'b0;
    bit done = 1'b0;
    int    exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    baud_tick_gen #(.LEGACY_MODE(1'b0)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .tx_idle(tx_idle), .sys_stb(sys_stb), .xtal_stb(xtal_stb),
        .cfg_rdata(rd), .baud_tick(tick)
    );

    baud_tick_gen #(.LEGACY_MODE(1'b1)) uut_leg (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .tx_idle(tx_idle), .sys_stb(sys_stb), .xtal_stb(xtal_stb),
        .cfg_rdata(rd_l), .baud_tick(tick_l)
    );

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        forever begin
            @(negedge clk);
            sys_stb  = 1'b1;
            xtal_stb = ((cyc % xgap) == 0);
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // monitor: timestamps every tick, compares intervals against the queue
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && (mon_leg ? tick_l : tick)) begin
                if (exp_q.size() > 0) begin
                    int    e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (e != 0) check((cyc - last_ts) == e, t, cyc - last_ts, e);
                end
                last_ts = cyc;
            end
        end
    end

    function automatic logic [31:0] mk(input int n, input bit en, input bit src, input logic [1:0] pre);
        logic [22:0] nn;
        nn = n[22:0];
        return {4'h0, pre, 1'b0, src, en, nn};
    endfunction

    task automatic push(input int period, input int count, input string req);
        for (int i = 0; i < count; i++) begin
            exp_q.push_back(period);
            tag_q.push_back(req);
        end
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 4000 && exp_q.size() > 0; i++) @(negedge clk);
        if (exp_q.size() > 0) begin
            check(1'b0, req, exp_q.size(), 0);
            exp_q.delete();
            tag_q.delete();
        end
    endtask

    // write with tx_idle high; commit edge becomes the interval origin
    task automatic apply(input logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we  = 1'b0;
        last_ts = cyc;
        check(rd == (d & 32'h0DFF_FFFF), "R8", rd, d & 32'h0DFF_FFFF);
    endtask

    task automatic count_ticks(input int cycles, output int cnt);
        cnt = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (tick) cnt++;
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            check(1'b0, "watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(rd == 32'h0, "R10", rd, 0);
        check(rd_l == 32'h0, "R10", rd_l, 0);
        count_ticks(40, cnt);
        check(cnt == 0, "R10", cnt, 0);

        // R7 / R5 reserved and legacy bits
        apply(32'hFFFF_FFFF);
        check(rd == 32'h0DFF_FFFF, "R7", rd, 32'h0DFF_FFFF);
        check(rd_l == 32'h01FF_FFFF, "R5", rd_l, 32'h01FF_FFFF);

        // R1 / R9: crystal pass-through, first interval from commit edge
        apply(mk(4, 1, 1, 2'b01));
        push(5, 1, "R9"); push(5, 3, "R1"); drain("R1");
        // R4 prescaler codes
        apply(mk(3, 1, 1, 2'b00));
        push(12, 3, "R4"); drain("R4");
        apply(mk(2, 1, 1, 2'b10));
        push(6, 3, "R4"); drain("R4");
        apply(mk(6, 1, 1, 2'b11));
        push(14, 3, "R4"); drain("R4");
        // R3 / R6 system path
        apply(mk(2, 1, 0, 2'b01));
        push(12, 3, "R6"); drain("R6");
        apply(mk(0, 1, 0, 2'b01));
        push(4, 3, "R3"); drain("R3");

        // R1 sparse crystal strobe: counts reference pulses, not cycles
        xgap = 2;
        apply(mk(3, 1, 1, 2'b01));
        push(0, 1, "R1"); push(8, 3, "R1"); drain("R1");
        xgap = 1;

        // R2 enable clear
        apply(mk(1, 0, 1, 2'b01));
        check(rd[23] == 1'b0, "R2", rd[23], 0);
        repeat (3) @(negedge clk);
        count_ticks(60, cnt);
        check(cnt == 0, "R2", cnt, 0);

        // R8 pending write while transmitter busy
        apply(mk(7, 1, 1, 2'b01));
        push(8, 2, "R8"); drain("R8");
        @(negedge clk);
        tx_idle   = 1'b0;
        cfg_we    = 1'b1;
        cfg_wdata = mk(2, 1, 1, 2'b01);
        push(8, 3, "R8");
        @(negedge clk);
        cfg_we = 1'b0;
        check(rd == mk(2, 1, 1, 2'b01), "R8", rd, mk(2, 1, 1, 2'b01));
        drain("R8");
        @(negedge clk);
        tx_idle = 1'b1;
        @(negedge clk);
        last_ts = cyc;
        push(3, 3, "R8"); drain("R8");

        // R5 legacy crystal path fixed at divide by 3
        mon_leg = 1'b1;
        apply(mk(4, 1, 1, 2'b01));
        check(rd_l == mk(4, 1, 1, 2'b00), "R5", rd_l, mk(4, 1, 1, 2'b00));
        push(15, 3, "R5"); drain("R5");
        mon_leg = 1'b0;

        // R10 reset mid-run
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(rd == 32'h0, "R10", rd, 0);
        count_ticks(30, cnt);
        check(cnt == 0, "R10", cnt, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule